// File: doc/BRIEF.md
# SPI/DSI Frame Interleaver

This block merges two kinds of outgoing traffic onto a single serial line: ordinary SPI command frames and frames that carry serialized signal snapshots (DSI frames). A new frame starts only when the line is idle or while the last bit of the current frame is on the line. A frame that has started always runs to its end. Every frame begins with a type bit. The payload then follows, most significant bit first. As each frame goes out, a bit comes back on the receive pin for every payload bit. These bits are gathered into one receive register per frame type.

Both sources use a request/acknowledge handshake. A run-time mode input chooses the scheduling policy. In interleaved mode a waiting SPI frame normally takes the next boundary. The exception is when DSI has lost two contests in a row, in which case DSI goes first. In timed mode a period counter opens DSI slots, and SPI frames are sent only while no DSI slot is pending. Each frame type has its own one-cycle completion pulse.

Top module: `link_frame_interleaver`

## Requirements
- R1: Every frame starts with a type bit: 1 for an SPI frame and 0 for a DSI frame. The payload follows, most significant bit first. `link_active` stays high for exactly payload length + 1 consecutive cycles, beginning the cycle after the load edge.
- R2: The payload length is taken separately from `spi_len` or `dsi_len` when the frame is loaded. A value below 4 is treated as 4, and a value above 16 is treated as 16. Data bits above the payload length are not sent.
- R3: A frame is loaded only when the line is idle or during the last bit of the current frame. On an idle line a request is granted in the cycle it appears. A frame waiting behind another starts on the cycle after the other frame's last bit, so there is no gap between them.
- R4: An acknowledge is a one-cycle pulse. It is high during the cycle whose closing clock edge loads the frame. At most one acknowledge is high in any cycle.
- R5: `spi_done` or `dsi_done` pulses for exactly one cycle, in the cycle after the frame's last bit. Only the pulse matching the frame's type fires.
- R6: Payload bits are sampled from `link_sdi` while the payload is on `link_sdo`. They are stored right-aligned, with zeros above the payload, into `spi_rx` or `dsi_rx` according to the frame type. The new value becomes visible together with that type's done pulse. The other receive register keeps its value.
- R7: In interleaved mode (`mode_timed`=0), a request that arrives alone at a boundary is granted. When both requests arrive at a boundary, SPI wins, unless DSI lost the previous two such contests in a row, in which case DSI wins.
- R8: While interleaved, the period counter is held at zero. In timed mode the counter advances every cycle and marks a DSI slot due every `dsi_period` cycles. A DSI frame is granted only while a slot is due. An SPI frame is granted only while no slot is due.
- R9: After reset, no frame is active, `link_sdo` is 0, both done pulses and both acknowledges are 0, and both receive registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one line bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_timed | input | 1 | 1 = timed slots, 0 = interleaved |
| spi_len | input | 5 | SPI payload length in bits |
| dsi_len | input | 5 | DSI payload length in bits |
| dsi_period | input | 8 | Cycles between DSI slots in timed mode |
| spi_req | input | 1 | SPI frame waiting |
| spi_data | input | 16 | SPI payload, right-aligned |
| spi_ack | output | 1 | SPI frame taken |
| dsi_req | input | 1 | DSI frame waiting |
| dsi_data | input | 16 | DSI payload, right-aligned |
| dsi_ack | output | 1 | DSI frame taken |
| link_sdo | output | 1 | Serial output |
| link_sdi | input | 1 | Serial input |
| link_active | output | 1 | High while a frame bit is on the line |
| spi_rx | output | 16 | Last received SPI payload |
| dsi_rx | output | 16 | Last received DSI payload |
| spi_done | output | 1 | SPI frame complete pulse |
| dsi_done | output | 1 | DSI frame complete pulse |

## Verification
Each acknowledge is combinational, so it is checked shortly after the request is driven, before the loading edge. The type bit appears one edge later, and each payload bit appears one edge after the previous one. The done pulse and the receive register update are checked one edge after the last bit, and the done pulse is checked low again one edge after that.

For contested and timed traffic, the bench counts the cycles between acknowledges. It compares those counts with gaps worked out by hand:
- The gap after a frame equals that frame's payload length.
- In timed mode the grant cycles are fixed by the period counter, which starts from zero when the mode switches.

// File: rtl/lfi_pkg.sv
`timescale 1ns/1ps
package lfi_pkg;
   typedef enum logic {KIND_DSI = 1'b0, KIND_SPI = 1'b1} frame_kind_e;
   localparam int N_KINDS = 2;
endpackage

// File: rtl/lfi_slot_timer.sv
`timescale 1ns/1ps
module lfi_slot_timer #(
   parameter int PERIOD_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic [PERIOD_W-1:0] period,
   input  logic                slot_taken,
   output logic                due
);
   logic [PERIOD_W-1:0] pcnt_q;
   logic                due_q;
   logic                wrap;

   // a period of zero behaves like a period of one
   assign wrap = en && (({1'b0, pcnt_q} + 1'b1) >= {1'b0, period});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt_q <= '0;
         due_q  <= 1'b0;
      end else if (!en) begin
         pcnt_q <= '0;
         due_q  <= 1'b0;
      end else begin
         pcnt_q <= wrap ? '0 : pcnt_q + 1'b1;
         due_q  <= wrap | (due_q & ~slot_taken);
      end
   end

   assign due = due_q;

   // R8
   idle_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !due);

   // R8
   due_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && due && !slot_taken) |=> due);
endmodule

// File: rtl/lfi_arbiter.sv
`timescale 1ns/1ps
module lfi_arbiter #(
   parameter int FAIR_LIMIT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic timed,
   input  logic boundary,
   input  logic spi_req,
   input  logic dsi_req,
   input  logic due,
   output logic spi_grant,
   output logic dsi_grant
);
   logic dsi_first;

   generate
      if (FAIR_LIMIT == 0) begin : g_strict
         assign dsi_first = 1'b0;
      end else begin : g_fair
         localparam int LOSS_W = $clog2(FAIR_LIMIT + 1);
         logic [LOSS_W-1:0] loss_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               loss_q <= '0;
            end else if (dsi_grant) begin
               loss_q <= '0;
            end else if (!timed && spi_grant && dsi_req &&
                         loss_q < LOSS_W'(FAIR_LIMIT)) begin
               loss_q <= loss_q + 1'b1;
            end
         end
         assign dsi_first = (loss_q >= LOSS_W'(FAIR_LIMIT));
      end
   endgenerate

   always_comb begin
      spi_grant = 1'b0;
      dsi_grant = 1'b0;
      if (boundary) begin
         if (timed) begin
            dsi_grant = due & dsi_req;
            spi_grant = ~due & spi_req;
         end else begin
            dsi_grant = dsi_req & (~spi_req | dsi_first);
            spi_grant = spi_req & ~dsi_grant;
         end
      end
   end

   // R4
   grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({spi_grant, dsi_grant}));

   // R8
   timed_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (timed && dsi_grant) |-> due);

   // R7
   lone_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!timed && boundary && (spi_req ^ dsi_req)) |-> (spi_grant | dsi_grant));
endmodule

// File: rtl/lfi_shifter.sv
`timescale 1ns/1ps
module lfi_shifter
   import lfi_pkg::*;
#(
   parameter int MAX_LEN = 16,
   parameter int LEN_W   = 5,
   parameter int CNT_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  frame_kind_e        load_kind,
   input  logic [LEN_W-1:0]   load_len,
   input  logic [MAX_LEN-1:0] load_data,
   input  logic               sdi,
   output logic               sdo,
   output logic               active,
   output logic               boundary,
   output logic               last_bit,
   output frame_kind_e        cur_kind,
   output logic [MAX_LEN-1:0] word_now
);
   logic [MAX_LEN:0]   tx_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [MAX_LEN-2:0] rx_q;
   logic               first_q;
   frame_kind_e        kind_q;
   logic [LEN_W-1:0]   gap;
   logic [MAX_LEN-1:0] aligned;

   assign gap     = LEN_W'(MAX_LEN) - load_len;
   assign aligned = load_data << gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q    <= '0;
         cnt_q   <= '0;
         rx_q    <= '0;
         first_q <= 1'b0;
         kind_q  <= KIND_DSI;
      end else if (load) begin
         tx_q    <= {load_kind, aligned};
         cnt_q   <= CNT_W'(load_len) + 1'b1;
         rx_q    <= '0;
         first_q <= 1'b1;
         kind_q  <= load_kind;
      end else if (cnt_q != '0) begin
         tx_q    <= tx_q << 1;
         cnt_q   <= cnt_q - 1'b1;
         first_q <= 1'b0;
         if (!first_q) rx_q <= {rx_q[MAX_LEN-3:0], sdi};
      end
   end

   assign active   = (cnt_q != '0);
   assign boundary = (cnt_q <= CNT_W'(1));
   assign last_bit = (cnt_q == CNT_W'(1));
   assign sdo      = active & tx_q[MAX_LEN];
   assign cur_kind = kind_q;
   assign word_now = {rx_q, sdi};

   // R3
   load_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> boundary);

   // R1
   type_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (active && sdo == logic'($past(load_kind))));
endmodule

// File: rtl/link_frame_interleaver.sv
`timescale 1ns/1ps
module link_frame_interleaver
   import lfi_pkg::*;
#(
   parameter int MAX_LEN    = 16,
   parameter int MIN_LEN    = 4,
   parameter int PERIOD_W   = 8,
   parameter int FAIR_LIMIT = 2,
   localparam int LEN_W     = $clog2(MAX_LEN + 1),
   localparam int CNT_W     = $clog2(MAX_LEN + 2)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mode_timed,
   input  logic [LEN_W-1:0]   spi_len,
   input  logic [LEN_W-1:0]   dsi_len,
   input  logic [PERIOD_W-1:0] dsi_period,
   input  logic               spi_req,
   input  logic [MAX_LEN-1:0] spi_data,
   output logic               spi_ack,
   input  logic               dsi_req,
   input  logic [MAX_LEN-1:0] dsi_data,
   output logic               dsi_ack,
   output logic               link_sdo,
   input  logic               link_sdi,
   output logic               link_active,
   output logic [MAX_LEN-1:0] spi_rx,
   output logic [MAX_LEN-1:0] dsi_rx,
   output logic               spi_done,
   output logic               dsi_done
);
   generate
      if (MIN_LEN < 3 || MIN_LEN > MAX_LEN) begin : g_bad_len
         $error("link_frame_interleaver: MIN_LEN must lie in 3..MAX_LEN");
      end
      if (PERIOD_W < 1) begin : g_bad_period
         $error("link_frame_interleaver: PERIOD_W must be at least 1");
      end
      if (FAIR_LIMIT < 0) begin : g_bad_fair
         $error("link_frame_interleaver: FAIR_LIMIT must not be negative");
      end
   endgenerate

   function automatic logic [LEN_W-1:0] fit_len(input logic [LEN_W-1:0] l);
      if (l < LEN_W'(MIN_LEN)) return LEN_W'(MIN_LEN);
      if (l > LEN_W'(MAX_LEN)) return LEN_W'(MAX_LEN);
      return l;
   endfunction

   logic               spi_grant, dsi_grant, due, boundary, last_bit, load;
   frame_kind_e        load_kind, cur_kind;
   logic [LEN_W-1:0]   load_len;
   logic [MAX_LEN-1:0] load_data, word_now;

   lfi_slot_timer #(.PERIOD_W(PERIOD_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .en(mode_timed), .period(dsi_period),
      .slot_taken(dsi_grant), .due(due)
   );

   lfi_arbiter #(.FAIR_LIMIT(FAIR_LIMIT)) u_arb (
      .clk(clk), .rst_n(rst_n), .timed(mode_timed), .boundary(boundary),
      .spi_req(spi_req), .dsi_req(dsi_req), .due(due),
      .spi_grant(spi_grant), .dsi_grant(dsi_grant)
   );

   assign load      = spi_grant | dsi_grant;
   assign load_kind = spi_grant ? KIND_SPI : KIND_DSI;
   assign load_len  = spi_grant ? fit_len(spi_len) : fit_len(dsi_len);
   assign load_data = spi_grant ? spi_data : dsi_data;

   lfi_shifter #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(load), .load_kind(load_kind),
      .load_len(load_len), .load_data(load_data), .sdi(link_sdi),
      .sdo(link_sdo), .active(link_active), .boundary(boundary),
      .last_bit(last_bit), .cur_kind(cur_kind), .word_now(word_now)
   );

   generate
      for (genvar k = 0; k < N_KINDS; k++) begin : g_cls
         logic [MAX_LEN-1:0] rx_q;
         logic               done_q;
         logic               mine;
         assign mine = last_bit && (logic'(cur_kind) == 1'(k));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rx_q   <= '0;
               done_q <= 1'b0;
            end else begin
               done_q <= mine;
               if (mine) rx_q <= word_now;
            end
         end
      end
   endgenerate

   assign spi_rx   = g_cls[1].rx_q;
   assign dsi_rx   = g_cls[0].rx_q;
   assign spi_done = g_cls[1].done_q;
   assign dsi_done = g_cls[0].done_q;
   assign spi_ack  = spi_grant;
   assign dsi_ack  = dsi_grant;

   // R5
   done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({spi_done, dsi_done}));

   // R4
   spi_ack_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spi_ack |-> spi_req);

   // R4
   dsi_ack_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dsi_ack |-> dsi_req);

   // R6
   rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_done |-> $stable(spi_rx));
endmodule

// File: tb/sim_link_frame_interleaver.sv
`timescale 1ns/1ps
module sim_link_frame_interleaver;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_timed = 1'b0;
   logic [4:0]  spi_len = 5'd4, dsi_len = 5'd4;
   logic [7:0]  dsi_period = 8'd10;
   logic        spi_req = 1'b0, dsi_req = 1'b0;
   logic [15:0] spi_data = '0, dsi_data = '0;
   logic        spi_ack, dsi_ack, link_sdo, link_sdi, link_active;
   logic [15:0] spi_rx, dsi_rx;
   logic        spi_done, dsi_done;
   logic        inv = 1'b0;
   int          checks = 0, errors = 0;
   bit          finished = 0;
   logic [15:0] exp_spi = '0, exp_dsi = '0;

   always #2.5 clk = ~clk;
   assign link_sdi = link_sdo ^ inv;

   link_frame_interleaver u0 (
      .clk(clk), .rst_n(rst_n), .mode_timed(mode_timed),
      .spi_len(spi_len), .dsi_len(dsi_len), .dsi_period(dsi_period),
      .spi_req(spi_req), .spi_data(spi_data), .spi_ack(spi_ack),
      .dsi_req(dsi_req), .dsi_data(dsi_data), .dsi_ack(dsi_ack),
      .link_sdo(link_sdo), .link_sdi(link_sdi), .link_active(link_active),
      .spi_rx(spi_rx), .dsi_rx(dsi_rx), .spi_done(spi_done), .dsi_done(dsi_done)
   );

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send_one(input bit is_spi, input int len_in, input logic [15:0] data);
      int L;
      logic [15:0] mask, exp_rx;
      L = (len_in < 4) ? 4 : ((len_in > 16) ? 16 : len_in);
      mask = 16'((32'h1 << L) - 1);
      exp_rx = (data ^ {16{inv}}) & mask;
      if (is_spi) begin
         spi_len = 5'(len_in); spi_data = data; spi_req = 1'b1;
      end else begin
         dsi_len = 5'(len_in); dsi_data = data; dsi_req = 1'b1;
      end
      #1;
      chk((is_spi ? spi_ack : dsi_ack) && !(is_spi ? dsi_ack : spi_ack),
          "R4 ack on idle line", {spi_ack, dsi_ack}, is_spi ? 2 : 1);
      tick;
      spi_req = 1'b0; dsi_req = 1'b0;
      for (int k = 0; k <= L; k++) begin
         logic eb;
         eb = (k == 0) ? is_spi : data[L-k];
         chk(link_active && link_sdo == eb, "R1 frame bit",
             {link_active, link_sdo}, {1'b1, eb});
         chk(!spi_done && !dsi_done, "R5 no early done", {spi_done, dsi_done}, 0);
         if (k == 0) chk(!spi_ack && !dsi_ack, "R4 single ack", {spi_ack, dsi_ack}, 0);
         tick;
      end
      chk(!link_active, "R2 clamped frame length", link_active, 0);
      if (is_spi) exp_spi = exp_rx; else exp_dsi = exp_rx;
      chk(spi_done == is_spi && dsi_done == !is_spi, "R5 done kind",
          {spi_done, dsi_done}, is_spi ? 2 : 1);
      chk(spi_rx == exp_spi, "R6 spi_rx", spi_rx, exp_spi);
      chk(dsi_rx == exp_dsi, "R6 dsi_rx", dsi_rx, exp_dsi);
      tick;
      chk(!spi_done && !dsi_done, "R5 one-cycle done", {spi_done, dsi_done}, 0);
   endtask

   task automatic wait_ack(output int waited);
      waited = 0;
      while (!spi_ack && !dsi_ack && waited < 80) begin
         tick;
         waited++;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick;
      // R9 reset state
      chk(!link_active && !link_sdo, "R9 line idle", {link_active, link_sdo}, 0);
      chk(!spi_done && !dsi_done && !spi_ack && !dsi_ack, "R9 pulses low",
          {spi_done, dsi_done, spi_ack, dsi_ack}, 0);
      chk(spi_rx == 0 && dsi_rx == 0, "R9 rx cleared", spi_rx | dsi_rx, 0);

      // R1 R2 R5 R6 sweep over lengths, both kinds, both loopback polarities
      for (int len = 2; len <= 20; len++) begin
         inv = len[0];
         send_one(1'b1, len, 16'hA5C3 ^ 16'(len * 16'h1111));
         inv = ~len[0];
         send_one(1'b0, len, 16'h3C96 ^ 16'(len * 16'h0707));
      end
      inv = 1'b0;

      // R7 R3 contested interleaved traffic
      spi_len = 5'd5; dsi_len = 5'd7; spi_data = 16'h0015; dsi_data = 16'h0055;
      spi_req = 1'b1; dsi_req = 1'b1;
      #1;
      begin
         int prev_len;
         prev_len = 0;
         for (int i = 0; i < 9; i++) begin
            int w;
            bit exp_dsi;
            wait_ack(w);
            exp_dsi = (i % 3 == 2);
            chk(dsi_ack == exp_dsi && spi_ack == !exp_dsi, "R7 contest order",
                {spi_ack, dsi_ack}, exp_dsi ? 1 : 2);
            chk(w == prev_len, "R3 gapless boundary", w, prev_len);
            prev_len = dsi_ack ? 7 : 5;
            tick;
         end
      end
      spi_req = 1'b0; dsi_req = 1'b0;
      repeat (20) tick;

      // R8 timed slots: expected grants S@0, D@17, D@22, S@27
      spi_len = 5'd16; dsi_len = 5'd4; dsi_period = 8'd10;
      mode_timed = 1'b1; spi_req = 1'b1; dsi_req = 1'b1;
      #1;
      for (int i = 0; i < 4; i++) begin
         int w, exp_w;
         bit exp_dsi;
         wait_ack(w);
         exp_dsi = (i == 1 || i == 2);
         exp_w = (i == 0) ? 0 : ((i == 1) ? 16 : 4);
         chk(dsi_ack == exp_dsi && spi_ack == !exp_dsi, "R8 slot kind",
             {spi_ack, dsi_ack}, exp_dsi ? 1 : 2);
         chk(w == exp_w, "R8 slot timing", w, exp_w);
         tick;
      end
      spi_req = 1'b0; dsi_req = 1'b0;
      repeat (20) tick;

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule